// File: doc/BRIEF.md
# Floating-point class-based fixup unit

The unit takes a single-precision source operand and assigns it to one of eight classes: quiet NaN, signalling NaN, zero of either sign, exactly +1.0, negative infinity, positive infinity, negative finite and positive finite. A 32-bit control word holds one 4-bit substitution code per class. The code for the source's class picks the result. It can pass the destination operand through, pass the source through, or supply a NaN, an infinity, a zero or one of several fixed constants. No arithmetic is performed; the result is always selected.

A caller can build functions such as signum from one control word. With the word 0xA9A9A800 the unit returns +1.0, -1.0 or +0.0 by sign. NaNs pass through when the destination and source are the same value. A denormals-as-zero input makes denormal sources behave as +0.0. The result is registered once, and a valid strobe travels alongside it.

Top module: `fixup_unit`

## Requirements
- R1: The source is classified in this priority order: NaN (exponent all ones, mantissa nonzero), then infinity (exponent all ones, mantissa zero, sign picks negative or positive), then zero (exponent and mantissa zero, either sign), then the exact pattern 0x3F800000, then negative or positive finite by sign. The code for each class sits in a fixed control-word field: quiet NaN bits 3:0, signalling NaN 7:4, zero 11:8, +1.0 15:12, negative infinity 19:16, positive infinity 23:20, negative finite 27:24, positive finite 31:28.
- R2: A NaN is quiet when mantissa bit 22 is set. It is signalling when bit 22 is clear and the mantissa is nonzero.
- R3: Code 0 returns the destination operand unchanged. Code 1 returns the source operand. Code 2 returns the quiet NaN {source sign, 0x7FC00000 low 31 bits}. Code 3 returns 0xFFC00000.
- R4: Codes 4, 5 and 6 return 0xFF800000, 0x7F800000 and infinity with the source sign. Codes 7 and 8 return 0x80000000 and 0x00000000.
- R5: Codes 9 to 15 return, in order: 0xBF800000 (-1.0), 0x3F800000 (+1.0), 0x3F000000 (+0.5), 0x42B40000 (+90.0), 0x3FC90FDB (pi/2), 0x7F7FFFFF and 0xFF7FFFFF.
- R6: With denormals-as-zero high, a denormal source (exponent zero, mantissa nonzero) is classified as zero. Codes 1, 2 and 6 then treat the source as +0.0. With the input low, a denormal falls into the finite class of its sign.
- R7: With control word 0xA9A9A800 and the destination equal to the source, the unit gives signum. Positive values and +infinity give 0x3F800000. Negative values and -infinity give 0xBF800000. Either zero gives 0x00000000. Any NaN is returned unchanged.
- R8: The output valid is the input valid delayed by exactly one clock. The result changes only in the clock after an accepted input and holds otherwise.
- R9: A synchronous active-high reset clears the output valid and the result to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and control word are presented this cycle |
| dst_op | input | 32 | Destination operand, returned by code 0 |
| src_op | input | 32 | Source operand, classified and used by codes 1, 2 and 6 |
| ctl_word | input | 32 | Eight 4-bit substitution codes, one per class |
| daz_en | input | 1 | Treat denormal sources as +0.0 |
| out_valid | output | 1 | Result valid, one clock after in_valid |
| result | output | 32 | Selected value |

## Verification
The bench builds the unit with its default widths: 8 exponent bits, 23 mantissa bits and 4-bit codes. These defaults place every class representative and every constant encoding at the exact single-precision bit pattern the requirements state. The bench sends one operand from each of the eight classes with each of the sixteen codes, with both signs wherever the sign changes the result. It then runs the signum word over signed zeros, infinities, denormals with denormals-as-zero on and off, the largest finite values and both NaN kinds. Directed tests cover the held result between inputs and a reset in the middle of a run.

// File: rtl/fixup_pkg.sv
package fixup_pkg;
    localparam int EXP_W    = 8;
    localparam int MAN_W    = 23;
    localparam int WORD_W   = 1 + EXP_W + MAN_W;
    localparam int CODE_W   = 4;
    localparam int N_CLASS  = 8;
    localparam int CTL_W    = CODE_W * N_CLASS;

    typedef enum logic [2:0] {
        CL_QNAN = 3'd0,
        CL_SNAN = 3'd1,
        CL_ZERO = 3'd2,
        CL_ONE  = 3'd3,
        CL_NINF = 3'd4,
        CL_PINF = 3'd5,
        CL_NEG  = 3'd6,
        CL_POS  = 3'd7
    } fp_class_e;

    typedef enum logic [CODE_W-1:0] {
        SB_DEST    = 4'd0,
        SB_SRC     = 4'd1,
        SB_QNAN_S  = 4'd2,
        SB_INDEF   = 4'd3,
        SB_NINF    = 4'd4,
        SB_PINF    = 4'd5,
        SB_INF_S   = 4'd6,
        SB_NZERO   = 4'd7,
        SB_PZERO   = 4'd8,
        SB_NONE    = 4'd9,
        SB_PONE    = 4'd10,
        SB_HALF    = 4'd11,
        SB_NINETY  = 4'd12,
        SB_HALFPI  = 4'd13,
        SB_PMAX    = 4'd14,
        SB_NMAX    = 4'd15
    } subst_e;

    localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};
    localparam logic [EXP_W-1:0] EXP_BIAS = {1'b0, {(EXP_W-1){1'b1}}};

    localparam logic [WORD_W-1:0] K_ONE    = {1'b0, EXP_BIAS, {MAN_W{1'b0}}};
    localparam logic [WORD_W-1:0] K_HALF   = {1'b0, EXP_BIAS - 1'b1, {MAN_W{1'b0}}};
    localparam logic [WORD_W-1:0] K_MAXMAG = {1'b0, EXP_ONES - 1'b1, {MAN_W{1'b1}}};
    localparam logic [WORD_W-1:0] K_INFMAG = {1'b0, EXP_ONES, {MAN_W{1'b0}}};
    localparam logic [WORD_W-1:0] K_QNMAG  = {1'b0, EXP_ONES, 1'b1, {(MAN_W-1){1'b0}}};
    localparam logic [WORD_W-1:0] K_NINETY = 32'h42B4_0000;
    localparam logic [WORD_W-1:0] K_HALFPI = 32'h3FC9_0FDB;
endpackage

// File: rtl/fixup_classify.sv
module fixup_classify
    import fixup_pkg::*;
(
    input  logic [WORD_W-1:0] op,
    input  logic              daz_en,
    output fp_class_e         cls,
    output logic              flush
);
    logic              sgn;
    logic [EXP_W-1:0]  expo;
    logic [MAN_W-1:0]  man;
    logic              exp_max;
    logic              exp_min;
    logic              man_zero;

    assign sgn      = op[WORD_W-1];
    assign expo     = op[WORD_W-2 -: EXP_W];
    assign man      = op[MAN_W-1:0];
    assign exp_max  = (expo == EXP_ONES);
    assign exp_min  = (expo == '0);
    assign man_zero = (man == '0);

    // denormal forced to zero under the flush control
    assign flush = daz_en && exp_min && !man_zero;

    always_comb begin
        if (exp_max && !man_zero) begin
            cls = man[MAN_W-1] ? CL_QNAN : CL_SNAN;
        end else if (exp_max) begin
            cls = sgn ? CL_NINF : CL_PINF;
        end else if (exp_min && (man_zero || daz_en)) begin
            cls = CL_ZERO;
        end else if (op == K_ONE) begin
            cls = CL_ONE;
        end else begin
            cls = sgn ? CL_NEG : CL_POS;
        end
    end
endmodule

// File: rtl/fixup_select.sv
module fixup_select
    import fixup_pkg::*;
(
    input  logic [WORD_W-1:0] dst_op,
    input  logic [WORD_W-1:0] src_op,
    input  logic              flush,
    input  subst_e            code,
    output logic [WORD_W-1:0] value
);
    logic [WORD_W-1:0] src_eff;
    logic              s_sgn;
    logic [WORD_W-2:0] sgn_pad;

    assign src_eff = flush ? '0 : src_op;
    assign s_sgn   = src_eff[WORD_W-1];
    assign sgn_pad = '0;

    always_comb begin
        unique case (code)
            SB_DEST:   value = dst_op;
            SB_SRC:    value = src_eff;
            SB_QNAN_S: value = K_QNMAG | {s_sgn, sgn_pad};
            SB_INDEF:  value = K_QNMAG | {1'b1, sgn_pad};
            SB_NINF:   value = K_INFMAG | {1'b1, sgn_pad};
            SB_PINF:   value = K_INFMAG;
            SB_INF_S:  value = K_INFMAG | {s_sgn, sgn_pad};
            SB_NZERO:  value = {1'b1, sgn_pad};
            SB_PZERO:  value = '0;
            SB_NONE:   value = K_ONE | {1'b1, sgn_pad};
            SB_PONE:   value = K_ONE;
            SB_HALF:   value = K_HALF;
            SB_NINETY: value = K_NINETY;
            SB_HALFPI: value = K_HALFPI;
            SB_PMAX:   value = K_MAXMAG;
            SB_NMAX:   value = K_MAXMAG | {1'b1, sgn_pad};
            default:   value = dst_op;
        endcase
    end
endmodule

// File: rtl/fixup_unit.sv
module fixup_unit
    import fixup_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] dst_op,
    input  logic [WORD_W-1:0] src_op,
    input  logic [CTL_W-1:0]  ctl_word,
    input  logic              daz_en,
    output logic              out_valid,
    output logic [WORD_W-1:0] result
);
    typedef struct packed {
        logic              vld;
        logic [WORD_W-1:0] res;
    } stage_t;

    stage_t            st_d;
    stage_t            st_q;
    fp_class_e         cls;
    logic              flush;
    logic [CODE_W-1:0] field [N_CLASS];
    subst_e            code;
    logic [WORD_W-1:0] pick;

    fixup_classify u_class (
        .op     (src_op),
        .daz_en (daz_en),
        .cls    (cls),
        .flush  (flush)
    );

    for (genvar i = 0; i < N_CLASS; i++) begin : g_field
        assign field[i] = ctl_word[i*CODE_W +: CODE_W];
    end

    assign code = subst_e'(field[cls]);

    fixup_select u_sel (
        .dst_op (dst_op),
        .src_op (src_op),
        .flush  (flush),
        .code   (code),
        .value  (pick)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.res = pick;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
endmodule

// File: rtl/fixup_unit_chk.sv
module fixup_unit_chk (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [31:0] dst_op,
    input logic [31:0] src_op,
    input logic [31:0] ctl_word,
    input logic        out_valid,
    input logic [31:0] result
);
    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && result == 32'h0));

    // R8
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);

    // R8
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(result)));

    // R3
    dest_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_word == 32'h0) |=> (result == $past(dst_op)));

    // R7
    signum_range_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ctl_word == 32'hA9A9A800 && src_op[30:23] != 8'hFF)
        |=> (result == 32'h3F800000 || result == 32'hBF800000 || result == 32'h0));
endmodule

bind fixup_unit fixup_unit_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .dst_op    (dst_op),
    .src_op    (src_op),
    .ctl_word  (ctl_word),
    .out_valid (out_valid),
    .result    (result)
);

// File: tb/tb_fixup_unit.sv
`timescale 1ns/1ps
module tb_fixup_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] dst_op = '0;
    logic [31:0] src_op = '0;
    logic [31:0] ctl_word = '0;
    logic        daz_en = 1'b0;
    logic        out_valid;
    logic [31:0] result;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    fixup_unit dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dst_op(dst_op),
        .src_op(src_op), .ctl_word(ctl_word), .daz_en(daz_en),
        .out_valid(out_valid), .result(result)
    );

    typedef struct packed {
        logic [31:0] val;
        logic        daz;
        logic [31:0] exp;
    } vec_t;

    // R7 signum vectors, destination equals source
    localparam vec_t SGN_TBL [16] = '{
        '{32'h00000000, 1'b0, 32'h00000000},
        '{32'h80000000, 1'b0, 32'h00000000},
        '{32'h7F800000, 1'b0, 32'h3F800000},
        '{32'hFF800000, 1'b0, 32'hBF800000},
        '{32'h00000001, 1'b0, 32'h3F800000},
        '{32'h80000001, 1'b0, 32'hBF800000},
        '{32'h00000001, 1'b1, 32'h00000000},
        '{32'h807FFFFF, 1'b1, 32'h00000000},
        '{32'h7F7FFFFF, 1'b0, 32'h3F800000},
        '{32'hFF7FFFFF, 1'b0, 32'hBF800000},
        '{32'h7FC00001, 1'b0, 32'h7FC00001},
        '{32'h7F800001, 1'b0, 32'h7F800001},
        '{32'hFFC00000, 1'b0, 32'hFFC00000},
        '{32'h3F800000, 1'b0, 32'h3F800000},
        '{32'h3F000000, 1'b0, 32'h3F800000},
        '{32'hC2B40000, 1'b0, 32'hBF800000}
    };

    function automatic int class_of(input logic [31:0] v, input logic dz);
        logic [7:0]  e = v[30:23];
        logic [22:0] m = v[22:0];
        if (e == 8'hFF && m != 0) return m[22] ? 0 : 1;
        if (e == 8'hFF) return v[31] ? 4 : 5;
        if (e == 8'h00 && (m == 0 || dz)) return 2;
        if (v == 32'h3F800000) return 3;
        return v[31] ? 6 : 7;
    endfunction

    function automatic logic [31:0] model(input logic [31:0] d, input logic [31:0] s,
                                          input logic [31:0] c, input logic dz);
        int          k  = class_of(s, dz);
        logic [3:0]  cd = c[k*4 +: 4];
        logic [31:0] se = (dz && s[30:23] == 8'h00) ? 32'h0 : s;
        case (cd)
            4'd0:  return d;
            4'd1:  return se;
            4'd2:  return {se[31], 31'h7FC00000};
            4'd3:  return 32'hFFC00000;
            4'd4:  return 32'hFF800000;
            4'd5:  return 32'h7F800000;
            4'd6:  return {se[31], 31'h7F800000};
            4'd7:  return 32'h80000000;
            4'd8:  return 32'h00000000;
            4'd9:  return 32'hBF800000;
            4'd10: return 32'h3F800000;
            4'd11: return 32'h3F000000;
            4'd12: return 32'h42B40000;
            4'd13: return 32'h3FC90FDB;
            4'd14: return 32'h7F7FFFFF;
            default: return 32'hFF7FFFFF;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic apply(input string tag, input logic [31:0] d, input logic [31:0] s,
                         input logic [31:0] c, input logic dz, input logic [31:0] exp);
        @(negedge clk);
        dst_op = d; src_op = s; ctl_word = c; daz_en = dz; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check({tag, " valid"}, {31'h0, out_valid}, 32'h1);
        check(tag, result, exp);
    endtask

    initial begin
        logic [31:0] reps [8];
        logic [31:0] held;
        reps[0] = 32'h7FC12345; reps[1] = 32'hFF812345; reps[2] = 32'h80000000;
        reps[3] = 32'h3F800000; reps[4] = 32'hFF800000; reps[5] = 32'h7F800000;
        reps[6] = 32'hC0490FDB; reps[7] = 32'h00000001;

        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset valid", {31'h0, out_valid}, 32'h0);
        check("R9 reset result", result, 32'h0);
        rst = 1'b0;

        for (int i = 0; i < 16; i++) begin
            apply("R7 signum", SGN_TBL[i].val, SGN_TBL[i].val, 32'hA9A9A800,
                  SGN_TBL[i].daz, SGN_TBL[i].exp);
        end

        // R1 / R2 / R3 / R4 / R5: every class with every code
        for (int k = 0; k < 8; k++) begin
            for (int c = 0; c < 16; c++) begin
                logic [31:0] w = 32'h5A5A5A5A ^ (32'(k) * 32'h01010101);
                string tg = (c < 4) ? "R1 R2 R3 code" : (c < 9) ? "R1 R4 code" : "R1 R5 code";
                w[k*4 +: 4] = 4'(c);
                apply(tg, 32'h12345678, reps[k], w, 1'b0,
                      model(32'h12345678, reps[k], w, 1'b0));
            end
        end

        // R4 / R3 sign-dependent codes on a positive source
        apply("R3 qnan sign +", 32'h0, 32'h40000000, 32'h20000000, 1'b0, 32'h7FC00000);
        apply("R4 inf sign +", 32'h0, 32'h40000000, 32'h60000000, 1'b0, 32'h7F800000);
        apply("R4 inf sign -", 32'h0, 32'hC0000000, 32'h06000000, 1'b0, 32'hFF800000);

        // R6 denormals-as-zero
        apply("R6 daz src", 32'h11111111, 32'h80000005, 32'hFFFFF1FF, 1'b1, 32'h00000000);
        apply("R6 daz qnan", 32'h11111111, 32'h80000005, 32'hFFFFF2FF, 1'b1, 32'h7FC00000);
        apply("R6 daz inf", 32'h11111111, 32'h80000005, 32'hFFFFF6FF, 1'b1, 32'h7F800000);
        apply("R6 no daz neg", 32'h11111111, 32'h80000005, 32'hF9FFF1FF, 1'b0, 32'hBF800000);
        apply("R6 no daz src", 32'h11111111, 32'h80000005, 32'hF1FFF8FF, 1'b0, 32'h80000005);

        // R8 result holds while idle
        held = result;
        @(negedge clk);
        dst_op = 32'hDEADBEEF; src_op = 32'h40400000; ctl_word = 32'h0;
        repeat (3) @(negedge clk);
        check("R8 idle valid", {31'h0, out_valid}, 32'h0);
        check("R8 idle hold", result, held);

        // R9 reset mid-run
        apply("R3 dest", 32'hCAFEF00D, 32'h40400000, 32'h0, 1'b0, 32'hCAFEF00D);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R9 mid reset valid", {31'h0, out_valid}, 32'h0);
        check("R9 mid reset result", result, 32'h0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule